// File: doc/BRIEF.md
# SMI Capability Handshake and APM Command Dispatcher

This block settles, once per reset, which system-management-interrupt features firmware and the platform agree on. Software fills a 64-bit request register one byte at a time and then pokes a commit strobe. The block checks the request against a fixed host capability mask and a rule that ties the two CPU hotplug features to broadcast delivery. A passing request is copied into the agreed set and locks it until the next reset. A failing request leaves everything as it was, so software may retry.

The same block watches writes to the power-management command port. Two reserved command values switch the ACPI enable state on or off. Any other value raises a one-cycle SMI pulse, but only when the command-port enable bit of the SMI enable register is set. The pulse goes to every CPU when broadcast was agreed, and otherwise only to the CPU that issued the write. A lock bit in the power-management control word freezes itself and bit 0 of the SMI enable register.

All inputs are plain write strobes with no back-pressure: the block accepts a strobe on every cycle it is high. Every output is a register that shows the effect of a write one clock after the write is sampled.

Top module: `smi_negotiate_top`

## Requirements
- R1: After reset, `req_features`, `neg_features`, `neg_ok`, `acpi_en`, `smi_pulse`, `pmcon` and `smi_en` are all zero.
- R2: A byte write with `req_idx` = k places `req_byte` in `req_features[8k+7:8k]` (little-endian byte order) and leaves the other bytes unchanged, one cycle after the write.
- R3: A commit (`ok_wr`) whose request sets any bit that is clear in `HOST_CAPS` (default 64'h3) leaves `neg_ok` at 0 and `neg_features` unchanged.
- R4: A commit whose request sets bit 1 (CPU hotplug) or bit 2 (CPU hot-unplug) while bit 0 (broadcast) is clear is rejected, and `neg_ok` stays 0.
- R5: A commit of a valid request while `neg_ok` is 0 sets `neg_features` to the request register's value before that cycle's byte write and sets `neg_ok` to 1, one cycle later.
- R6: While `neg_ok` is 1, commits have no effect: `neg_features` and `neg_ok` hold until reset.
- R7: Command 8'hF1 sets `acpi_en` and command 8'hF0 clears it, one cycle later. Neither command produces any `smi_pulse` bit.
- R8: Any other command produces no SMI pulse while bit 5 (`APM_EN_BIT`) of `smi_en` is 0.
- R9: With bit 5 of `smi_en` set and bit 0 of `neg_features` set, any other command sets all `NCPU` bits of `smi_pulse` for exactly the one cycle after the write.
- R10: With bit 5 of `smi_en` set and bit 0 of `neg_features` clear, any other command sets only bit `apm_cpu` of `smi_pulse` for the one cycle after the write.
- R11: Once bit 4 (`LOCK_BIT`) of `pmcon` is 1, a `pmcon` write cannot clear it. The other bits still take the written value.
- R12: While bit 4 of `pmcon` is 1, a `smi_en` write leaves bit 0 of `smi_en` unchanged. The other bits still take the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_wr | input | 1 | Request byte write strobe |
| req_idx | input | 3 | Byte lane of the request register (0 = least significant) |
| req_byte | input | 8 | Byte to write |
| ok_wr | input | 1 | Commit strobe that starts validation |
| req_features | output | 64 | Current request register |
| neg_features | output | 64 | Agreed feature set |
| neg_ok | output | 1 | Agreement locked |
| pmcon_wr | input | 1 | Power-management control word write strobe |
| pmcon_wdata | input | 16 | Control word write data |
| pmcon | output | 16 | Control word |
| smien_wr | input | 1 | SMI enable register write strobe |
| smien_wdata | input | 32 | SMI enable write data |
| smi_en | output | 32 | SMI enable register |
| apm_wr | input | 1 | Command port write strobe |
| apm_cmd | input | 8 | Command value |
| apm_cpu | input | CPU_IDX_W | Index of the CPU that issued the command write |
| acpi_en | output | 1 | ACPI enable state |
| smi_pulse | output | NCPU | One-cycle SMI request for each CPU |

## Verification
The negotiation is driven with a request that has bytes outside the host mask, with a subset that sets hot-unplug, and with hotplug set alone. It is then driven with an empty valid set, and a later conflicting commit shows that the lock holds. These cases separate the superset check from the dependency check and from the one-shot lock. Command writes cover the two ACPI values, a plain command with the enable bit clear, and plain commands after non-broadcast and after broadcast agreement, which separates the per-CPU fan-out from the all-CPU fan-out. A behavioural model predicts every output on every clock.

// File: rtl/smi_neg_pkg.sv
package smi_neg_pkg;
  localparam int FEAT_W        = 64;
  localparam int FEAT_BYTES    = FEAT_W / 8;
  localparam int FEAT_IDX_W    = $clog2(FEAT_BYTES);
  localparam int BIT_BCAST     = 0;
  localparam int BIT_HOTPLUG   = 1;
  localparam int BIT_HOTUNPLUG = 2;
  localparam logic [7:0] CMD_ACPI_ON  = 8'hF1;
  localparam logic [7:0] CMD_ACPI_OFF = 8'hF0;

  // A request passes when it stays inside the host mask and any hotplug
  // feature comes together with broadcast delivery.
  function automatic logic feat_acceptable(input logic [FEAT_W-1:0] req,
                                           input logic [FEAT_W-1:0] host);
    logic inside_host;
    logic dep_ok;
    inside_host = ((req & ~host) == '0);
    dep_ok      = !((req[BIT_HOTPLUG] | req[BIT_HOTUNPLUG]) && !req[BIT_BCAST]);
    return inside_host && dep_ok;
  endfunction
endpackage

// File: rtl/smi_feat_neg.sv
module smi_feat_neg
  import smi_neg_pkg::*;
#(
  parameter logic [FEAT_W-1:0] HOST_CAPS = 64'h3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  byte_wr,
  input  logic [FEAT_IDX_W-1:0] byte_idx,
  input  logic [7:0]            byte_data,
  input  logic                  commit,
  output logic [FEAT_W-1:0]     req_q,
  output logic [FEAT_W-1:0]     neg_q,
  output logic                  ok_q
);
  logic [7:0] lane_q [FEAT_BYTES];
  logic       accept;

  for (genvar b = 0; b < FEAT_BYTES; b++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q[b] <= '0;
      end else if (byte_wr && (byte_idx == FEAT_IDX_W'(b))) begin
        lane_q[b] <= byte_data;
      end
    end
    assign req_q[8*b +: 8] = lane_q[b];
  end

  assign accept = commit && !ok_q && feat_acceptable(req_q, HOST_CAPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_q <= '0;
      ok_q  <= 1'b0;
    end else if (accept) begin
      neg_q <= req_q;
      ok_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/smi_lock_regs.sv
module smi_lock_regs #(
  parameter int PMCON_W  = 16,
  parameter int SMIEN_W  = 32,
  parameter int LOCK_BIT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pmcon_wr,
  input  logic [PMCON_W-1:0] pmcon_wdata,
  input  logic               smien_wr,
  input  logic [SMIEN_W-1:0] smien_wdata,
  output logic [PMCON_W-1:0] pmcon_q,
  output logic [SMIEN_W-1:0] smien_q
);
  logic               locked;
  logic [PMCON_W-1:0] pm_wmask;
  logic [SMIEN_W-1:0] se_wmask;

  assign locked = pmcon_q[LOCK_BIT];

  always_comb begin
    pm_wmask = '1;
    se_wmask = '1;
    if (locked) begin
      pm_wmask[LOCK_BIT] = 1'b0;
      se_wmask[0]        = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pmcon_q <= '0;
      smien_q <= '0;
    end else begin
      if (pmcon_wr) pmcon_q <= (pmcon_wdata & pm_wmask) | (pmcon_q & ~pm_wmask);
      if (smien_wr) smien_q <= (smien_wdata & se_wmask) | (smien_q & ~se_wmask);
    end
  end
endmodule

// File: rtl/smi_apm_dispatch.sv
module smi_apm_dispatch
  import smi_neg_pkg::*;
#(
  parameter int NCPU      = 4,
  parameter int CPU_IDX_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 apm_wr,
  input  logic [7:0]           apm_cmd,
  input  logic [CPU_IDX_W-1:0] apm_cpu,
  input  logic                 port_en,
  input  logic                 bcast,
  output logic                 acpi_en_q,
  output logic [NCPU-1:0]      pulse_q
);
  logic            is_on;
  logic            is_off;
  logic            fire;
  logic [NCPU-1:0] pulse_d;

  assign is_on  = apm_cmd == CMD_ACPI_ON;
  assign is_off = apm_cmd == CMD_ACPI_OFF;
  assign fire   = apm_wr && !is_on && !is_off && port_en;

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    assign pulse_d[c] = fire && (bcast || (apm_cpu == CPU_IDX_W'(c)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acpi_en_q <= 1'b0;
      pulse_q   <= '0;
    end else begin
      pulse_q <= pulse_d;
      if (apm_wr && is_on)       acpi_en_q <= 1'b1;
      else if (apm_wr && is_off) acpi_en_q <= 1'b0;
    end
  end
endmodule

// File: rtl/smi_negotiate_top.sv
module smi_negotiate_top
  import smi_neg_pkg::*;
#(
  parameter int          NCPU       = 4,
  parameter int          CPU_IDX_W  = (NCPU > 1) ? $clog2(NCPU) : 1,
  parameter logic [63:0] HOST_CAPS  = 64'h3,
  parameter int          PMCON_W    = 16,
  parameter int          SMIEN_W    = 32,
  parameter int          LOCK_BIT   = 4,
  parameter int          APM_EN_BIT = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_wr,
  input  logic [2:0]           req_idx,
  input  logic [7:0]           req_byte,
  input  logic                 ok_wr,
  output logic [63:0]          req_features,
  output logic [63:0]          neg_features,
  output logic                 neg_ok,
  input  logic                 pmcon_wr,
  input  logic [PMCON_W-1:0]   pmcon_wdata,
  output logic [PMCON_W-1:0]   pmcon,
  input  logic                 smien_wr,
  input  logic [SMIEN_W-1:0]   smien_wdata,
  output logic [SMIEN_W-1:0]   smi_en,
  input  logic                 apm_wr,
  input  logic [7:0]           apm_cmd,
  input  logic [CPU_IDX_W-1:0] apm_cpu,
  output logic                 acpi_en,
  output logic [NCPU-1:0]      smi_pulse
);
  smi_feat_neg #(.HOST_CAPS(HOST_CAPS)) u_neg (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_wr   (req_wr),
    .byte_idx  (req_idx),
    .byte_data (req_byte),
    .commit    (ok_wr),
    .req_q     (req_features),
    .neg_q     (neg_features),
    .ok_q      (neg_ok)
  );

  smi_lock_regs #(.PMCON_W(PMCON_W), .SMIEN_W(SMIEN_W), .LOCK_BIT(LOCK_BIT)) u_lock (
    .clk         (clk),
    .rst_n       (rst_n),
    .pmcon_wr    (pmcon_wr),
    .pmcon_wdata (pmcon_wdata),
    .smien_wr    (smien_wr),
    .smien_wdata (smien_wdata),
    .pmcon_q     (pmcon),
    .smien_q     (smi_en)
  );

  smi_apm_dispatch #(.NCPU(NCPU), .CPU_IDX_W(CPU_IDX_W)) u_apm (
    .clk       (clk),
    .rst_n     (rst_n),
    .apm_wr    (apm_wr),
    .apm_cmd   (apm_cmd),
    .apm_cpu   (apm_cpu),
    .port_en   (smi_en[APM_EN_BIT]),
    .bcast     (neg_features[BIT_BCAST]),
    .acpi_en_q (acpi_en),
    .pulse_q   (smi_pulse)
  );
endmodule

// File: rtl/smi_negotiate_checker.sv
module smi_negotiate_checker
  import smi_neg_pkg::*;
#(
  parameter int          NCPU      = 4,
  parameter logic [63:0] HOST_CAPS = 64'h3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [63:0]     neg_features,
  input logic            neg_ok,
  input logic            lock_bit,
  input logic            smien_bit0,
  input logic            smien_apm,
  input logic            apm_wr,
  input logic [7:0]      apm_cmd,
  input logic [NCPU-1:0] smi_pulse
);
  AST_NEG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    neg_ok |=> (neg_ok && $stable(neg_features))); // R6
  AST_NEG_WITHIN_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    neg_ok |-> ((neg_features & ~HOST_CAPS) == '0)); // R3
  AST_NEG_DEPENDENCY: assert property (@(posedge clk) disable iff (!rst_n)
    neg_ok |-> !((neg_features[BIT_HOTPLUG] | neg_features[BIT_HOTUNPLUG]) && !neg_features[BIT_BCAST])); // R4
  AST_ACPI_CMD_NO_SMI: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_wr && (apm_cmd == CMD_ACPI_ON || apm_cmd == CMD_ACPI_OFF)) |=> (smi_pulse == '0)); // R7
  AST_SMI_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_wr && !smien_apm) |=> (smi_pulse == '0)); // R8
  AST_PULSE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_pulse != '0) |-> $past(apm_wr)); // R9
  AST_PULSE_FANOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_pulse != '0) |-> ($past(neg_features[BIT_BCAST]) ? (&smi_pulse) : ($countones(smi_pulse) == 1))); // R10
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lock_bit |=> lock_bit); // R11
  AST_SMIEN_BIT0_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    lock_bit |=> $stable(smien_bit0)); // R12
endmodule

bind smi_negotiate_top smi_negotiate_checker #(.NCPU(NCPU), .HOST_CAPS(HOST_CAPS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .neg_features (neg_features),
  .neg_ok       (neg_ok),
  .lock_bit     (pmcon[LOCK_BIT]),
  .smien_bit0   (smi_en[0]),
  .smien_apm    (smi_en[APM_EN_BIT]),
  .apm_wr       (apm_wr),
  .apm_cmd      (apm_cmd),
  .smi_pulse    (smi_pulse)
);

// File: tb/smi_negotiate_top_test.sv
`timescale 1ns/1ps
module smi_negotiate_top_test;
  localparam int          NCPU = 4;
  localparam int          CW   = 2;
  localparam logic [63:0] HOST = 64'h3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_wr = 1'b0;
  logic [2:0]  req_idx = '0;
  logic [7:0]  req_byte = '0;
  logic        ok_wr = 1'b0;
  logic [63:0] req_features, neg_features;
  logic        neg_ok;
  logic        pmcon_wr = 1'b0;
  logic [15:0] pmcon_wdata = '0;
  logic [15:0] pmcon;
  logic        smien_wr = 1'b0;
  logic [31:0] smien_wdata = '0;
  logic [31:0] smi_en;
  logic        apm_wr = 1'b0;
  logic [7:0]  apm_cmd = '0;
  logic [CW-1:0] apm_cpu = '0;
  logic        acpi_en;
  logic [NCPU-1:0] smi_pulse;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  smi_negotiate_top #(.NCPU(NCPU), .HOST_CAPS(HOST)) uut (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_idx(req_idx), .req_byte(req_byte),
    .ok_wr(ok_wr), .req_features(req_features), .neg_features(neg_features), .neg_ok(neg_ok),
    .pmcon_wr(pmcon_wr), .pmcon_wdata(pmcon_wdata), .pmcon(pmcon),
    .smien_wr(smien_wr), .smien_wdata(smien_wdata), .smi_en(smi_en),
    .apm_wr(apm_wr), .apm_cmd(apm_cmd), .apm_cpu(apm_cpu),
    .acpi_en(acpi_en), .smi_pulse(smi_pulse)
  );

  // Behavioural reference model, advanced on every rising edge.
  logic [63:0] m_req, m_neg;
  logic        m_ok, m_acpi;
  logic [15:0] m_pmcon;
  logic [31:0] m_smien;
  logic [NCPU-1:0] m_pulse;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_req = '0; m_neg = '0; m_ok = 0; m_acpi = 0;
      m_pmcon = '0; m_smien = '0; m_pulse = '0;
    end else begin
      logic [63:0] o_req, o_neg;
      logic        o_ok;
      logic [15:0] o_pm;
      logic [31:0] o_se;
      bit          good;
      o_req = m_req; o_neg = m_neg; o_ok = m_ok; o_pm = m_pmcon; o_se = m_smien;
      good = ((o_req & ~HOST) == 0);
      if ((o_req[1] || o_req[2]) && !o_req[0]) good = 0;
      if (ok_wr && !o_ok && good) begin m_neg = o_req; m_ok = 1; end
      if (req_wr) m_req[req_idx*8 +: 8] = req_byte;
      m_pulse = '0;
      if (apm_wr) begin
        if (apm_cmd == 8'hF1) m_acpi = 1;
        else if (apm_cmd == 8'hF0) m_acpi = 0;
        else if (o_se[5]) begin
          if (o_neg[0]) m_pulse = '1;
          else if (int'(apm_cpu) < NCPU) m_pulse[apm_cpu] = 1'b1;
        end
      end
      if (pmcon_wr) m_pmcon = o_pm[4] ? (pmcon_wdata | 16'h0010) : pmcon_wdata;
      if (smien_wr) m_smien = o_pm[4] ? {smien_wdata[31:1], o_se[0]} : smien_wdata;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 req_features model", req_features, m_req);
      chk("R5 neg_features model", neg_features, m_neg);
      chk("R5 neg_ok model", {63'd0, neg_ok}, {63'd0, m_ok});
      chk("R7 acpi_en model", {63'd0, acpi_en}, {63'd0, m_acpi});
      chk("R9 smi_pulse model", {60'd0, smi_pulse}, {60'd0, m_pulse});
      chk("R11 pmcon model", {48'd0, pmcon}, {48'd0, m_pmcon});
      chk("R12 smi_en model", {32'd0, smi_en}, {32'd0, m_smien});
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog act=running exp=finished");
    finish_run();
  end

  task automatic wr_byte(input int idx, input logic [7:0] d);
    @(negedge clk); req_wr = 1; req_idx = 3'(idx); req_byte = d;
    @(negedge clk); req_wr = 0;
  endtask
  task automatic set_req(input logic [63:0] v);
    for (int i = 0; i < 8; i++) wr_byte(i, v[8*i +: 8]);
  endtask
  task automatic commit();
    @(negedge clk); ok_wr = 1;
    @(negedge clk); ok_wr = 0;
  endtask
  task automatic apm(input logic [7:0] c, input int cpu);
    @(negedge clk); apm_wr = 1; apm_cmd = c; apm_cpu = CW'(cpu);
    @(negedge clk); apm_wr = 0;
  endtask
  task automatic wr_pm(input logic [15:0] d);
    @(negedge clk); pmcon_wr = 1; pmcon_wdata = d;
    @(negedge clk); pmcon_wr = 0;
  endtask
  task automatic wr_se(input logic [31:0] d);
    @(negedge clk); smien_wr = 1; smien_wdata = d;
    @(negedge clk); smien_wr = 0;
  endtask
  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    chk("R1 req", req_features, 0);
    chk("R1 neg", neg_features, 0);
    chk("R1 ok", {63'd0, neg_ok}, 0);
    chk("R1 acpi", {63'd0, acpi_en}, 0);
    chk("R1 pulse", {60'd0, smi_pulse}, 0);
    chk("R1 pmcon", {48'd0, pmcon}, 0);
    chk("R1 smi_en", {32'd0, smi_en}, 0);

    wr_byte(7, 8'hA5);
    wr_byte(0, 8'h3C);
    chk("R2 byte lanes", req_features, 64'hA500_0000_0000_003C);
    commit();
    chk("R3 high bits rejected", {63'd0, neg_ok}, 0);
    set_req(64'h5);
    commit();
    chk("R3 hot-unplug outside host rejected", {63'd0, neg_ok}, 0);
    chk("R3 neg unchanged", neg_features, 0);
    set_req(64'h2);
    commit();
    chk("R4 hotplug without broadcast rejected", {63'd0, neg_ok}, 0);
    set_req(64'h0);
    commit();
    chk("R5 empty set accepted", {63'd0, neg_ok}, 1);
    chk("R5 neg value", neg_features, 0);
    set_req(64'h3);
    commit();
    chk("R6 locked ok", {63'd0, neg_ok}, 1);
    chk("R6 locked neg", neg_features, 0);

    apm(8'h42, 1);
    chk("R8 disabled port no pulse", {60'd0, smi_pulse}, 0);
    wr_se(32'h21);
    apm(8'hF1, 0);
    chk("R7 acpi on", {63'd0, acpi_en}, 1);
    chk("R7 on no pulse", {60'd0, smi_pulse}, 0);
    apm(8'hF0, 0);
    chk("R7 acpi off", {63'd0, acpi_en}, 0);
    chk("R7 off no pulse", {60'd0, smi_pulse}, 0);
    apm(8'h42, 2);
    chk("R10 requester only", {60'd0, smi_pulse}, 64'h4);
    @(negedge clk);
    chk("R10 pulse one cycle", {60'd0, smi_pulse}, 0);

    wr_pm(16'h0010);
    wr_pm(16'h0003);
    chk("R11 lock sticky", {48'd0, pmcon}, 64'h13);
    wr_se(32'h20);
    chk("R12 bit0 held", {32'd0, smi_en}, 64'h21);
    wr_se(32'h0);
    chk("R12 other bits written", {32'd0, smi_en}, 64'h1);

    do_reset();
    chk("R1 ok after reset", {63'd0, neg_ok}, 0);
    chk("R1 pmcon after reset", {48'd0, pmcon}, 0);
    set_req(64'h3);
    commit();
    chk("R5 broadcast set", neg_features, 64'h3);
    wr_se(32'h20);
    apm(8'h07, 1);
    chk("R9 broadcast all cpus", {60'd0, smi_pulse}, 64'hF);
    @(negedge clk);
    chk("R9 pulse one cycle", {60'd0, smi_pulse}, 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule